// File: doc/BRIEF.md
# Vertical-First Element Step Unit

This block keeps the element position used while a vector engine runs in vertical-first mode. In that mode each vector instruction acts on one element only, and software moves on to the next element with an explicit step operation. The unit holds a source-step counter and a destination-step counter. A step advances both counters together and compares them with the current vector length. When a counter reaches the vector length, both counters go back to zero and the unit leaves vertical-first mode.

An operation is presented for one cycle on `op_valid` with its three mode flags, a record flag, a 7-bit immediate and the current vector length. The pattern vf=1, vs=0, ms=0 is a step. Any other valid pattern is a length-setting operation. Such an operation only loads the vertical-first mode bit from its vf flag, because the lengths are held elsewhere. When a step has the record flag set, the unit reports a four-bit condition result one cycle later. The immediate chooses what goes into that result: either the vector-length end test alone, or the inner, middle and outer loop-end flags of one of four remap schedule states, which come in on `loop_end`.

Top module: `vstep_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `src_step`, `dst_step`, `vf_mode` and `cr_valid` are all 0 after that edge.
- R2: A valid operation is a step only when op_vf=1, op_vs=0 and op_ms=0. Any other valid operation leaves both step counters unchanged.
- R3: A step without rollover makes both `src_step` and `dst_step` one greater after the clock edge, and the two counters always hold equal values.
- R4: Rollover happens when the incremented counter value equals `vl`. Then both counters become 0 and `vf_mode` becomes 0 after the edge.
- R5: A step with `vl` = 0 always rolls over, so the counters stay at 0 and `vf_mode` is cleared.
- R6: A valid operation that is not a step loads `vf_mode` with `op_vf`. A step without rollover leaves `vf_mode` unchanged.
- R7: `cr_valid` is high for exactly the one cycle after a step that had `op_rc`=1. It stays low after a step with `op_rc`=0, after any other operation and after idle cycles.
- R8: For immediates other than 2 to 5, the result has `cr_so` = `cr_eq` = rollover and `cr_lt` = `cr_gt` = 0.
- R9: For immediates 2, 3, 4 and 5, schedule state s = imm-2 is selected. Then `cr_eq` = loop_end[3s] (inner), `cr_lt` = loop_end[3s+1] (middle), `cr_gt` = loop_end[3s+2] (outer), and `cr_so` = rollover.
- R10: With `op_valid` low, the counters and `vf_mode` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_vf | input | 1 | Vertical-first flag of the operation |
| op_vs | input | 1 | Length-set flag of the operation |
| op_ms | input | 1 | Maximum-length-set flag of the operation |
| op_rc | input | 1 | Record flag: request a condition result |
| op_imm | input | 7 | Immediate; selects the reported test on a step |
| vl | input | 7 | Current vector length |
| loop_end | input | 12 | Loop-end flags, 3 per schedule state {outer, middle, inner} |
| src_step | output | 7 | Source element counter |
| dst_step | output | 7 | Destination element counter |
| vf_mode | output | 1 | Vertical-first mode bit |
| cr_valid | output | 1 | Condition result valid |
| cr_lt | output | 1 | Condition LT bit |
| cr_gt | output | 1 | Condition GT bit |
| cr_eq | output | 1 | Condition EQ bit |
| cr_so | output | 1 | Condition summary-overflow bit |

## Verification
The assertions assume that `vl` and `op_imm` are read only in the cycle where `op_valid` is high. The assertions do not assume that `vl` stays the same from one step to the next. The stimulus therefore changes `vl` freely between operations, and it sometimes makes `vl` smaller than the current count, which lets the counters wrap through 127. Most `vl` values are kept small, so that rollover, the `vl` = 0 case and every immediate selection are reached often.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
    localparam int STEP_W_DEF  = 7;
    localparam int IMM_W_DEF   = 7;
    localparam int N_SCHED_DEF = 4;
    localparam int LEVELS      = 3;
    localparam int SEL_BASE    = 2;

    typedef enum logic [1:0] {
        OPK_IDLE  = 2'd0,
        OPK_STEP  = 2'd1,
        OPK_SETUP = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    function automatic op_kind_e classify(input logic valid, input logic vf,
                                          input logic vs, input logic ms);
        if (!valid)
            return OPK_IDLE;
        else if (vf && !vs && !ms)
            return OPK_STEP;
        else
            return OPK_SETUP;
    endfunction
endpackage

// File: rtl/vstep_counter.sv
module vstep_counter #(
    parameter int W = vstep_pkg::STEP_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] nxt;

    assign nxt = cnt + W'(1);
    assign hit = (nxt == limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= clr ? '0 : nxt;
    end
endmodule

// File: rtl/vstep_condsel.sv
module vstep_condsel
    import vstep_pkg::*;
#(
    parameter int IMM_W   = IMM_W_DEF,
    parameter int N_SCHED = N_SCHED_DEF
) (
    input  logic [IMM_W-1:0]          imm,
    input  logic [N_SCHED*LEVELS-1:0] loop_end,
    input  logic                      rollover,
    output cond_t                     cond
);
    always_comb begin
        cond    = '0;
        cond.so = rollover;
        cond.eq = rollover;
        for (int s = 0; s < N_SCHED; s++) begin
            if (imm == IMM_W'(s + SEL_BASE)) begin
                cond.eq = loop_end[s*LEVELS + 0];
                cond.lt = loop_end[s*LEVELS + 1];
                cond.gt = loop_end[s*LEVELS + 2];
            end
        end
    end
endmodule

// File: rtl/vstep_unit.sv
module vstep_unit
    import vstep_pkg::*;
#(
    parameter int STEP_W  = STEP_W_DEF,
    parameter int IMM_W   = IMM_W_DEF,
    parameter int N_SCHED = N_SCHED_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      op_valid,
    input  logic                      op_vf,
    input  logic                      op_vs,
    input  logic                      op_ms,
    input  logic                      op_rc,
    input  logic [IMM_W-1:0]          op_imm,
    input  logic [STEP_W-1:0]         vl,
    input  logic [N_SCHED*LEVELS-1:0] loop_end,
    output logic [STEP_W-1:0]         src_step,
    output logic [STEP_W-1:0]         dst_step,
    output logic                      vf_mode,
    output logic                      cr_valid,
    output logic                      cr_lt,
    output logic                      cr_gt,
    output logic                      cr_eq,
    output logic                      cr_so
);
    localparam int N_CNT = 2;

    op_kind_e          kind;
    logic              is_step;
    logic              rollover;
    logic [N_CNT-1:0]  hit;
    logic [STEP_W-1:0] cnt [N_CNT];
    cond_t             cond_d, cond_q;
    logic              cvalid_q;

    assign kind     = classify(op_valid, op_vf, op_vs, op_ms);
    assign is_step  = (kind == OPK_STEP);
    assign rollover = (|hit) || (vl == '0);

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        vstep_counter #(.W(STEP_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .adv   (is_step),
            .clr   (rollover),
            .limit (vl),
            .cnt   (cnt[i]),
            .hit   (hit[i])
        );
    end

    vstep_condsel #(.IMM_W(IMM_W), .N_SCHED(N_SCHED)) u_sel (
        .imm      (op_imm),
        .loop_end (loop_end),
        .rollover (rollover),
        .cond     (cond_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vf_mode  <= 1'b0;
            cvalid_q <= 1'b0;
            cond_q   <= '0;
        end else begin
            cvalid_q <= is_step && op_rc;
            if (is_step && op_rc)
                cond_q <= cond_d;
            if (is_step && rollover)
                vf_mode <= 1'b0;
            else if (kind == OPK_SETUP)
                vf_mode <= op_vf;
        end
    end

    assign src_step = cnt[0];
    assign dst_step = cnt[1];
    assign cr_valid = cvalid_q;
    assign cr_lt    = cond_q.lt;
    assign cr_gt    = cond_q.gt;
    assign cr_eq    = cond_q.eq;
    assign cr_so    = cond_q.so;
endmodule

// File: rtl/vstep_chk.sv
module vstep_chk #(
    parameter int W = 7
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic         op_vf,
    input logic         op_vs,
    input logic         op_ms,
    input logic         op_rc,
    input logic [W-1:0] vl,
    input logic [W-1:0] src_step,
    input logic [W-1:0] dst_step,
    input logic         vf_mode,
    input logic         cr_valid
);
    logic stp;
    logic wraps;
    assign stp   = op_valid && op_vf && !op_vs && !op_ms;
    assign wraps = (vl == '0) || (W'(src_step + W'(1)) == vl);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (src_step == '0 && dst_step == '0 && !vf_mode && !cr_valid)); // R1
    AST_OTHER_KEEPS_STEPS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !stp) |=> ($stable(src_step) && $stable(dst_step))); // R2
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (stp && !wraps) |=> (src_step == W'($past(src_step) + W'(1)))); // R3
    AST_STEPS_MATCH: assert property (@(posedge clk) disable iff (rst)
        src_step == dst_step); // R3
    AST_ROLLOVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stp && wraps) |=> (src_step == '0 && dst_step == '0 && !vf_mode)); // R4
    AST_ZERO_VL_ROLLS: assert property (@(posedge clk) disable iff (rst)
        (stp && vl == '0) |=> (src_step == '0)); // R5
    AST_SETUP_LOADS_VF: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !stp) |=> (vf_mode == $past(op_vf))); // R6
    AST_COND_PULSE: assert property (@(posedge clk) disable iff (rst)
        (stp && op_rc) |=> cr_valid); // R7
    AST_COND_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(stp && op_rc) |=> !cr_valid); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(src_step) && $stable(vf_mode))); // R10
endmodule

bind vstep_unit vstep_chk #(.W(STEP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_vf    (op_vf),
    .op_vs    (op_vs),
    .op_ms    (op_ms),
    .op_rc    (op_rc),
    .vl       (vl),
    .src_step (src_step),
    .dst_step (dst_step),
    .vf_mode  (vf_mode),
    .cr_valid (cr_valid)
);

// File: tb/sim_vstep_unit.sv
`timescale 1ns/1ps
module sim_vstep_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_vf, op_vs, op_ms, op_rc;
    logic [6:0]  op_imm, vl;
    logic [11:0] loop_end;
    logic [6:0]  src_step, dst_step;
    logic        vf_mode, cr_valid, cr_lt, cr_gt, cr_eq, cr_so;

    int checks = 0;
    int fails  = 0;
    logic       done = 1'b0;
    logic [6:0] m_step;
    logic       m_vf;

    always #2.5 clk = ~clk;

    vstep_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_vf(op_vf),
        .op_vs(op_vs), .op_ms(op_ms), .op_rc(op_rc), .op_imm(op_imm),
        .vl(vl), .loop_end(loop_end), .src_step(src_step),
        .dst_step(dst_step), .vf_mode(vf_mode), .cr_valid(cr_valid),
        .cr_lt(cr_lt), .cr_gt(cr_gt), .cr_eq(cr_eq), .cr_so(cr_so)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cond(input logic [6:0] imm,
                                            input logic [11:0] le,
                                            input logic roll);
        int s;
        if (imm >= 7'd2 && imm <= 7'd5) begin
            s = int'(imm) - 2;
            return {le[3*s+1], le[3*s+2], le[3*s], roll}; // lt gt eq so
        end
        return {1'b0, 1'b0, roll, roll};
    endfunction

    task automatic check_state(input string req);
        check(req, "src_step", int'(src_step), int'(m_step));
        check(req, "dst_step", int'(dst_step), int'(m_step));
        check(req, "vf_mode",  int'(vf_mode),  int'(m_vf));
    endtask

    task automatic do_op(input logic vf, input logic vs, input logic ms,
                         input logic rc, input logic [6:0] imm,
                         input logic [6:0] len, input logic [11:0] le);
        logic       stp;
        logic       roll;
        logic [6:0] inc;
        logic [3:0] ec;
        @(negedge clk);
        op_valid = 1'b1; op_vf = vf; op_vs = vs; op_ms = ms; op_rc = rc;
        op_imm = imm; vl = len; loop_end = le;
        stp  = vf && !vs && !ms;
        inc  = m_step + 7'd1;
        roll = (len == 7'd0) || (inc == len);
        ec   = exp_cond(imm, le, roll);
        if (stp) begin
            m_step = roll ? 7'd0 : inc;
            if (roll) m_vf = 1'b0;
        end else begin
            m_vf = vf;
        end
        @(negedge clk);
        op_valid = 1'b0;
        op_vf = $urandom; op_vs = $urandom; op_ms = $urandom; op_rc = $urandom;
        if (stp) begin
            if (len == 7'd0) check_state("R5");
            else if (roll) check_state("R4");
            else check_state("R3");
        end else begin
            check_state("R2");
            check("R6", "vf_mode", int'(vf_mode), int'(vf));
        end
        check("R7", "cr_valid", int'(cr_valid), int'(stp && rc));
        if (stp && rc) begin
            if (imm >= 7'd2 && imm <= 7'd5)
                check("R9", "cond", int'({cr_lt, cr_gt, cr_eq, cr_so}), int'(ec));
            else
                check("R8", "cond", int'({cr_lt, cr_gt, cr_eq, cr_so}), int'(ec));
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; op_valid = 1'b0; op_vf = 1'b0; op_vs = 1'b0; op_ms = 1'b0;
        op_rc = 1'b0; op_imm = '0; vl = '0; loop_end = '0;
        m_step = '0; m_vf = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "src_step", int'(src_step), 0);
        check("R1", "dst_step", int'(dst_step), 0);
        check("R1", "vf_mode",  int'(vf_mode), 0);
        check("R1", "cr_valid", int'(cr_valid), 0);
        rst = 1'b0;

        // directed: enter vertical-first, step to VL=3
        do_op(1, 1, 0, 0, 7'd0, 7'd3, 12'h000);          // R6 setup sets vf
        do_op(1, 0, 0, 1, 7'd1, 7'd3, 12'h000);          // R3, R8
        do_op(1, 0, 0, 1, 7'd1, 7'd3, 12'h000);          // R3
        do_op(1, 0, 0, 1, 7'd1, 7'd3, 12'h000);          // R4 rollover
        do_op(1, 0, 1, 0, 7'd0, 7'd3, 12'h000);          // R6
        do_op(1, 0, 0, 0, 7'd1, 7'd0, 12'h000);          // R5 VL zero
        do_op(0, 0, 0, 1, 7'd1, 7'd3, 12'h000);          // R2 getvl-like, R7 quiet
        do_op(1, 0, 0, 1, 7'd2, 7'd9, 12'b000_000_000_110); // R9 state 0
        do_op(1, 0, 0, 1, 7'd3, 7'd9, 12'b000_000_101_000); // R9 state 1
        do_op(1, 0, 0, 1, 7'd4, 7'd9, 12'b000_011_000_000); // R9 state 2
        do_op(1, 0, 0, 1, 7'd5, 7'd9, 12'b111_000_000_000); // R9 state 3
        do_op(1, 0, 0, 1, 7'd6, 7'd9, 12'hFFF);          // R8 out-of-range imm
        do_op(1, 0, 0, 1, 7'd0, 7'd9, 12'hFFF);          // R8 imm 0

        // R10: idle cycles hold state
        repeat (4) @(negedge clk);
        check_state("R10");
        check("R10", "cr_valid", int'(cr_valid), 0);

        for (int n = 0; n < 600; n++) begin
            logic [6:0] len;
            logic [6:0] imm;
            logic       vf, vs, ms;
            len = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 9);
            imm = ($urandom % 10 == 0) ? 7'($urandom) : 7'($urandom % 8);
            if ($urandom % 10 < 6) begin
                vf = 1; vs = 0; ms = 0;
            end else begin
                vf = $urandom; vs = $urandom; ms = $urandom;
            end
            do_op(vf, vs, ms, 1'($urandom), imm, len, 12'($urandom));
            if ($urandom % 5 == 0) begin
                repeat (2) @(negedge clk);
                check_state("R10");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule